// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Ripple Blanking

This block is a purely combinational decoder. It takes one 4-bit binary-coded decimal digit and produces seven active-low segment drives for a common-anode style display. Two active-low controls sit beside the digit. The lamp-test input forces every segment on, so the display reads 8. The blank-in input suppresses a zero on this digit.

A blank-out output tells the next digit down that this digit was a suppressed zero. Several copies can be chained, from the most significant digit to the less significant ones, so that leading zeros go dark and embedded zeros stay visible.

The most significant digit has its blank-in tied low. Each blank-out feeds the blank-in of the next lower digit. The units digit normally has its blank-in held high, so a value of zero still shows a single 0. The six codes above nine are not decimal digits, but each one still drives a fixed, documented pattern and causes no fault.

Top module: `bcd_seg_decoder`

## Requirements
- R1: With lamp_test_n and blank_in_n high, codes 0 to 9 light these segments (seg_n bit 0 is a, bit 6 is g, 0 means lit): 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg, 7=abc, 8=abcdefg, 9=abcdfg.
- R2: With lamp_test_n low, seg_n is all zeros (all seven segments lit) for every code and every blank_in_n value.
- R3: With lamp_test_n high, blank_in_n low and code 0, seg_n is all ones (every segment dark).
- R4: blank_out_n is low exactly when blank_in_n is low and code is 0. Otherwise it is high, whatever lamp_test_n is.
- R5: With lamp_test_n high, the non-decimal codes light these segments: 10=deg, 11=cdg, 12=bfg, 13=adfg, 14=defg, 15=none.
- R6: A low blank_in_n has no effect on seg_n for any nonzero code.
- R7: In a four-digit chain, a digit above the units is dark exactly when it and every digit above it are 0. The units digit always shows its value.
- R8: Lamp test overrides blanking: lamp_test_n low with blank_in_n low and code 0 lights all segments.
- R9: Outputs follow the inputs within the same cycle, with no storage and no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| code | input | 4 | BCD digit to display |
| lamp_test_n | input | 1 | Active-low lamp test, lights all segments |
| blank_in_n | input | 1 | Active-low request to blank a zero digit |
| seg_n | output | 7 | Active-low segment drives, bit 0 = a through bit 6 = g |
| blank_out_n | output | 1 | Active-low flag: this digit was a blanked zero |

## Verification
Every result of this block is combinational, so seg_n and blank_out_n are due in the same cycle that the inputs change. The bench drives inputs just after a rising edge and samples at the following falling edge. That leaves half a period for the logic to settle and no edge in between. A single decoder is swept over all 64 combinations of code, lamp test and blank-in. A four-digit chain is then swept over all 65,536 values, and each digit's segments and the ripple outputs are checked against expectations computed from the digit values.

// File: rtl/bcd_seg_pkg.sv
package bcd_seg_pkg;
  localparam int CODE_W = 4;
  localparam int SEG_W  = 7;
  localparam int NUM_CODES = 1 << CODE_W;

  typedef logic [CODE_W-1:0] bcd_code_t;
  // lit mask: 1 = segment on, bit 0 = a ... bit 6 = g
  typedef logic [SEG_W-1:0]  seg_mask_t;

  localparam seg_mask_t SEG_ALL  = {SEG_W{1'b1}};
  localparam seg_mask_t SEG_NONE = {SEG_W{1'b0}};
endpackage

// File: rtl/bcd_seg_pattern.sv
module bcd_seg_pattern
  import bcd_seg_pkg::*;
(
  input  bcd_code_t code,
  output seg_mask_t lit
);
  always_comb begin
    unique case (code)
      4'd0:  lit = 7'h3F;
      4'd1:  lit = 7'h06;
      4'd2:  lit = 7'h5B;
      4'd3:  lit = 7'h4F;
      4'd4:  lit = 7'h66;
      4'd5:  lit = 7'h6D;
      4'd6:  lit = 7'h7D;
      4'd7:  lit = 7'h07;
      4'd8:  lit = 7'h7F;
      4'd9:  lit = 7'h6F;
      4'd10: lit = 7'h58;
      4'd11: lit = 7'h4C;
      4'd12: lit = 7'h62;
      4'd13: lit = 7'h69;
      4'd14: lit = 7'h78;
      default: lit = SEG_NONE;
    endcase
  end
endmodule

// File: rtl/bcd_zero_blank.sv
module bcd_zero_blank
  import bcd_seg_pkg::*;
(
  input  bcd_code_t code,
  input  logic      blank_in_n,
  output logic      blank_now,
  output logic      blank_out_n
);
  logic is_zero;
  assign is_zero     = (code == '0);
  assign blank_now   = is_zero & ~blank_in_n;
  assign blank_out_n = ~blank_now;
endmodule

// File: rtl/bcd_seg_drive.sv
module bcd_seg_drive
  import bcd_seg_pkg::*;
(
  input  seg_mask_t lit,
  input  logic      blank_now,
  input  logic      lamp_test_n,
  output logic [SEG_W-1:0] seg_n
);
  seg_mask_t on_mask;
  always_comb begin
    if (!lamp_test_n)   on_mask = SEG_ALL;
    else if (blank_now) on_mask = SEG_NONE;
    else                on_mask = lit;
  end
  assign seg_n = ~on_mask;
endmodule

// File: rtl/bcd_seg_decoder.sv
module bcd_seg_decoder
  import bcd_seg_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              lamp_test_n,
  input  logic              blank_in_n,
  output logic [SEG_W-1:0]  seg_n,
  output logic              blank_out_n
);
  seg_mask_t lit;
  logic      blank_now;

  bcd_seg_pattern u_pattern (
    .code (code),
    .lit  (lit)
  );

  bcd_zero_blank u_blank (
    .code        (code),
    .blank_in_n  (blank_in_n),
    .blank_now   (blank_now),
    .blank_out_n (blank_out_n)
  );

  bcd_seg_drive u_drive (
    .lit         (lit),
    .blank_now   (blank_now),
    .lamp_test_n (lamp_test_n),
    .seg_n       (seg_n)
  );
endmodule

// File: rtl/bcd_seg_decoder_chk.sv
module bcd_seg_decoder_chk
  import bcd_seg_pkg::*;
(
  input logic [CODE_W-1:0] code,
  input logic              lamp_test_n,
  input logic              blank_in_n,
  input logic [SEG_W-1:0]  seg_n,
  input logic              blank_out_n
);
  always_comb begin
    AST_LAMP_ALL_ON: assert (lamp_test_n || seg_n == '0); // R2
    AST_ZERO_DARK: assert (!(lamp_test_n && !blank_in_n && code == '0) || seg_n == '1); // R3
    AST_RIPPLE_OUT: assert ((blank_out_n == 1'b0) == (!blank_in_n && code == '0)); // R4
    AST_NONZERO_SHOWS: assert (!(lamp_test_n && code != '0 && code != '1) || seg_n != '1); // R6
    AST_EIGHT_FULL: assert (code != 4'd8 || seg_n == '0); // R1
  end
endmodule

bind bcd_seg_decoder bcd_seg_decoder_chk u_chk (
  .code        (code),
  .lamp_test_n (lamp_test_n),
  .blank_in_n  (blank_in_n),
  .seg_n       (seg_n),
  .blank_out_n (blank_out_n)
);

// File: tb/bcd_seg_decoder_tb.sv
module bcd_seg_decoder_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [3:0] code;
  logic       lamp_n, rbi_n;
  logic [6:0] seg_n;
  logic       rbo_n;

  bcd_seg_decoder u_dut (
    .code (code), .lamp_test_n (lamp_n), .blank_in_n (rbi_n),
    .seg_n (seg_n), .blank_out_n (rbo_n)
  );

  // four-digit chain, index 3 = most significant
  logic [3:0] dig [4];
  logic [6:0] cseg [4];
  logic       crbo [4];
  logic       crbi [4];
  assign crbi[3] = 1'b0;
  assign crbi[2] = crbo[3];
  assign crbi[1] = crbo[2];
  assign crbi[0] = 1'b1;

  for (genvar g = 0; g < 4; g++) begin : g_chain
    bcd_seg_decoder u_digit (
      .code (dig[g]), .lamp_test_n (1'b1), .blank_in_n (crbi[g]),
      .seg_n (cseg[g]), .blank_out_n (crbo[g])
    );
  end

  function automatic logic [6:0] exp_lit(input logic [3:0] c);
    case (c)
      4'd0: return 7'b0111111;  4'd1: return 7'b0000110;
      4'd2: return 7'b1011011;  4'd3: return 7'b1001111;
      4'd4: return 7'b1100110;  4'd5: return 7'b1101101;
      4'd6: return 7'b1111101;  4'd7: return 7'b0000111;
      4'd8: return 7'b1111111;  4'd9: return 7'b1101111;
      4'd10: return 7'b1011000; 4'd11: return 7'b1001100;
      4'd12: return 7'b1100010; 4'd13: return 7'b1101001;
      4'd14: return 7'b1111000; default: return 7'b0000000;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    code = '0; lamp_n = 1'b1; rbi_n = 1'b1;
    for (int i = 0; i < 4; i++) dig[i] = '0;
    @(negedge clk);
    // R9: idle state with plain inputs shows 0, no ripple
    check("R9 idle", {1'b0, seg_n}, {1'b0, ~exp_lit(4'd0)});
    check("R4 idle", {7'b0, rbo_n}, 8'h01);

    for (int lt = 0; lt < 2; lt++) begin
      for (int rb = 0; rb < 2; rb++) begin
        for (int c = 0; c < 16; c++) begin
          @(posedge clk);
          #1;
          code = c[3:0]; lamp_n = lt[0]; rbi_n = rb[0];
          @(negedge clk);
          begin
            logic [6:0] e;
            logic       eb;
            eb = (rb == 0 && c == 0) ? 1'b0 : 1'b1;
            if (lt == 0)        e = 7'h00;
            else if (eb == 1'b0) e = 7'h7F;
            else                e = ~exp_lit(c[3:0]);
            if (lt == 0 && rb == 0 && c == 0) check("R8 lamp over blank", {1'b0, seg_n}, {1'b0, e});
            else if (lt == 0)  check("R2 lamp test", {1'b0, seg_n}, {1'b0, e});
            else if (c == 0 && rb == 0) check("R3 zero blank", {1'b0, seg_n}, {1'b0, e});
            else if (rb == 0)  check("R6 blank-in on nonzero", {1'b0, seg_n}, {1'b0, e});
            else if (c < 10)   check("R1 digit", {1'b0, seg_n}, {1'b0, e});
            else               check("R5 nondecimal", {1'b0, seg_n}, {1'b0, e});
            check("R4 blank out", {7'b0, rbo_n}, {7'b0, eb});
          end
        end
      end
    end

    lamp_n = 1'b1; rbi_n = 1'b1; code = '0;
    for (int v = 0; v < 65536; v++) begin
      @(posedge clk);
      #1;
      for (int i = 0; i < 4; i++) dig[i] = v[4*i +: 4];
      @(negedge clk);
      begin
        logic lead;
        lead = 1'b1;
        for (int i = 3; i >= 0; i--) begin
          logic dark;
          lead = lead && (dig[i] == 4'd0);
          dark = lead && (i != 0);
          check("R7 chain digit", {1'b0, cseg[i]},
                {1'b0, dark ? 7'h7F : ~exp_lit(dig[i])});
          if (i != 0) check("R7 chain ripple", {7'b0, crbo[i]}, {7'b0, ~dark});
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule